// File: doc/BRIEF.md
# Vector Register Bank with Matrix Transpose

This block is the storage for sixteen 256-bit vector registers. It offers three views of the same 4096 bits. In the vector view, two read ports return whole registers and one write port takes a whole register. In the string view, the bank is four byte-addressed string registers of 128 bytes each. One byte port reads and one byte port writes. In the matrix view, the whole bank is a 64×64 bit matrix. A single command transposes the matrix in place over a fixed run of 64 cycles.

The two write ports follow valid/ready rules:
- A write is taken on a rising clock edge where both valid and ready are high.
- Ready on both ports is low while the transpose runs.
- Ready on both ports is also low in the cycle where a transpose command is presented while the block is idle.
- String-port ready is also low when the vector port presents a write in the same cycle, so the vector port has priority.
- A source that sees ready low must hold its request.

The block raises `wr_refused` on any write request made during a transpose, and `busy` shows that the transpose is still running. All reads are combinational. A read of a register or byte that is being written in the same cycle returns the new value.

Top module: `vrb_bank`

## Requirements
- R1: A vector write accepted on a clock edge replaces all 256 bits of register `vw_idx`. Both read ports (`ra_data`, `rb_data`) return the current contents of their addressed registers combinationally.
- R2: In a cycle where a write is being accepted, a read of the affected register or byte returns the new data. This holds for the vector read ports and for the string read port.
- R3: Byte i (0 to 127) of string register s is bits [8*(i mod 32) +: 8] of vector register 4*s + i/32. Vector registers 0–3 form string 0, 4–7 form string 1, 8–11 form string 2 and 12–15 form string 3.
- R4: An accepted string write changes only the addressed byte. The other 4095 bits are unchanged.
- R5: When the vector and string write ports are both valid in the same cycle, the vector write is taken and `sw_ready` is low, so the string write is not applied.
- R6: A transpose command (`tr_start`) seen while idle raises `busy` from the next cycle. `busy` stays high for exactly 64 cycles.
- R7: Matrix row r is bits [64*(r mod 4) +: 64] of vector register r/4. When the transpose ends, bit c of row r holds what bit r of row c held when the command was accepted.
- R8: While `busy` is high, and in the command cycle itself, both write readies are low and no write is applied. While `busy` is high, `wr_refused` is high whenever either write port is valid.
- R9: A synchronous reset clears all 4096 bits to zero and ends any transpose in progress (`busy` low).
- R10: A transpose command presented while `busy` is high is ignored. The running transpose keeps its length and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tr_start | input | 1 | Transpose command (single-cycle pulse) |
| busy | output | 1 | Transpose in progress |
| wr_refused | output | 1 | Write request made during a transpose |
| vw_valid | input | 1 | Vector write request |
| vw_ready | output | 1 | Vector write can be taken |
| vw_idx | input | 4 | Vector write register number |
| vw_data | input | 256 | Vector write data |
| sw_valid | input | 1 | String byte write request |
| sw_ready | output | 1 | String byte write can be taken |
| sw_str | input | 2 | String register for the write |
| sw_byte | input | 7 | Byte index within the string register for the write |
| sw_data | input | 8 | Byte value to write |
| ra_idx | input | 4 | Read port A register number |
| ra_data | output | 256 | Read port A data |
| rb_idx | input | 4 | Read port B register number |
| rb_data | output | 256 | Read port B data |
| sr_str | input | 2 | String register for the byte read |
| sr_byte | input | 7 | Byte index for the byte read |
| sr_data | output | 8 | Byte read data |

## Verification
The hardest condition to reach from the ports is a transpose of a full, distinct bank. Every one of the 4096 bits must be traced to its mirrored position, and the same run must also see refused writes and a repeated command. The bench first fills all sixteen registers with different multiplicative patterns. It then starts the transpose and counts busy cycles. Partway through the run, it presents a vector write, a string write and a second command. Finally, it compares every register against a transpose the bench computes itself. A second run is cut short by reset to show that it stops early and leaves the bank cleared.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  localparam int unsigned VRB_NREG  = 16;
  localparam int unsigned VRB_VBITS = 256;
  localparam int unsigned VRB_NSTR  = 4;
  localparam int unsigned VRB_SIDE  = 64;
endpackage

// File: rtl/vrb_store.sv
module vrb_store #(
  parameter int unsigned NREG  = vrb_pkg::VRB_NREG,
  parameter int unsigned VBITS = vrb_pkg::VRB_VBITS,
  parameter int unsigned SIDE  = vrb_pkg::VRB_SIDE,
  localparam int unsigned TOT  = NREG * VBITS,
  localparam int unsigned AW   = $clog2(TOT),
  localparam int unsigned IW   = $clog2(NREG),
  localparam int unsigned BW   = $clog2(TOT / 8),
  localparam int unsigned RW   = $clog2(SIDE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [IW-1:0]    reg_idx,
  input  logic [VBITS-1:0] reg_data,
  input  logic             byte_we,
  input  logic [BW-1:0]    byte_addr,
  input  logic [7:0]       byte_data,
  input  logic             row_we,
  input  logic [RW-1:0]    row_idx,
  input  logic [SIDE-1:0]  row_data,
  output logic [TOT-1:0]   mem
);
  localparam int unsigned VBL = AW - IW;
  localparam int unsigned SBL = AW - RW;

  logic [AW-1:0] reg_base, byte_base, row_base;
  assign reg_base  = {reg_idx, {VBL{1'b0}}};
  assign byte_base = {byte_addr, 3'b000};
  assign row_base  = {row_idx, {SBL{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else begin
      if (reg_we)  mem[reg_base  +: VBITS] <= reg_data;
      if (byte_we) mem[byte_base +: 8]     <= byte_data;
      if (row_we)  mem[row_base  +: SIDE]  <= row_data;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_we, byte_we, row_we}) <= 1); // R5

  AST_REG_LANDS: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> mem[$past(reg_base) +: VBITS] == $past(reg_data)); // R1

  AST_BYTE_LANDS: assert property (@(posedge clk) disable iff (rst)
    byte_we |=> mem[$past(byte_base) +: 8] == $past(byte_data)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mem == '0); // R9
endmodule

// File: rtl/vrb_xpose.sv
module vrb_xpose #(
  parameter int unsigned SIDE = vrb_pkg::VRB_SIDE,
  localparam int unsigned TOT = SIDE * SIDE,
  localparam int unsigned AW  = $clog2(TOT),
  localparam int unsigned RW  = $clog2(SIDE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TOT-1:0]  bank,
  output logic            busy,
  output logic            row_we,
  output logic [RW-1:0]   row_idx,
  output logic [SIDE-1:0] row_data
);
  localparam logic [RW-1:0] LAST = RW'(SIDE - 1);

  logic [TOT-1:0] shadow;
  logic [RW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && start) shadow <= bank;
  end

  // New row r bit c takes the snapshot's row c bit r
  for (genvar c = 0; c < SIDE; c++) begin : g_col
    localparam logic [AW-1:0] BASE = AW'(c * SIDE);
    assign row_data[c] = shadow[BASE + AW'(cnt)];
  end

  assign row_we  = busy;
  assign row_idx = cnt;

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R10

  AST_FIRST_ROW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cnt == '0); // R6

  AST_BUSY_RUN: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> busy); // R6

  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST) |=> !busy); // R6
endmodule

// File: rtl/vrb_bank.sv
module vrb_bank #(
  parameter int unsigned NREG  = vrb_pkg::VRB_NREG,
  parameter int unsigned VBITS = vrb_pkg::VRB_VBITS,
  parameter int unsigned NSTR  = vrb_pkg::VRB_NSTR,
  parameter int unsigned SIDE  = vrb_pkg::VRB_SIDE,
  localparam int unsigned TOT  = NREG * VBITS,
  localparam int unsigned AW   = $clog2(TOT),
  localparam int unsigned IW   = $clog2(NREG),
  localparam int unsigned SW   = $clog2(NSTR),
  localparam int unsigned SBW  = $clog2(TOT / 8 / NSTR),
  localparam int unsigned RW   = $clog2(SIDE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tr_start,
  output logic             busy,
  output logic             wr_refused,
  input  logic             vw_valid,
  output logic             vw_ready,
  input  logic [IW-1:0]    vw_idx,
  input  logic [VBITS-1:0] vw_data,
  input  logic             sw_valid,
  output logic             sw_ready,
  input  logic [SW-1:0]    sw_str,
  input  logic [SBW-1:0]   sw_byte,
  input  logic [7:0]       sw_data,
  input  logic [IW-1:0]    ra_idx,
  output logic [VBITS-1:0] ra_data,
  input  logic [IW-1:0]    rb_idx,
  output logic [VBITS-1:0] rb_data,
  input  logic [SW-1:0]    sr_str,
  input  logic [SBW-1:0]   sr_byte,
  output logic [7:0]       sr_data
);
  localparam int unsigned BW  = SW + SBW;
  localparam int unsigned VBL = AW - IW;
  localparam int unsigned LBW = BW - IW;

  logic [TOT-1:0]  mem;
  logic            row_we;
  logic [RW-1:0]   row_idx;
  logic [SIDE-1:0] row_data;
  logic            start_acc, vw_acc, sw_acc;
  logic [BW-1:0]   sw_addr, sr_addr;
  logic [IW-1:0]   sw_reg;
  logic [LBW-1:0]  sw_lane;

  // Arbitration: transpose command, then vector port, then string port
  assign start_acc  = tr_start && !busy;
  assign vw_ready   = !busy && !tr_start;
  assign sw_ready   = vw_ready && !vw_valid;
  assign vw_acc     = vw_valid && vw_ready;
  assign sw_acc     = sw_valid && sw_ready;
  assign wr_refused = busy && (vw_valid || sw_valid);

  assign sw_addr = {sw_str, sw_byte};
  assign sr_addr = {sr_str, sr_byte};
  assign sw_reg  = sw_addr[BW-1 -: IW];
  assign sw_lane = sw_addr[LBW-1:0];

  vrb_store #(.NREG(NREG), .VBITS(VBITS), .SIDE(SIDE)) u_store (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (vw_acc),
    .reg_idx  (vw_idx),
    .reg_data (vw_data),
    .byte_we  (sw_acc),
    .byte_addr(sw_addr),
    .byte_data(sw_data),
    .row_we   (row_we),
    .row_idx  (row_idx),
    .row_data (row_data),
    .mem      (mem)
  );

  vrb_xpose #(.SIDE(SIDE)) u_xpose (
    .clk     (clk),
    .rst     (rst),
    .start   (start_acc),
    .bank    (mem),
    .busy    (busy),
    .row_we  (row_we),
    .row_idx (row_idx),
    .row_data(row_data)
  );

  // Vector read ports with write-through from either write port
  logic [IW-1:0]    rd_idx [2];
  logic [VBITS-1:0] rd_val [2];
  assign rd_idx[0] = ra_idx;
  assign rd_idx[1] = rb_idx;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [AW-1:0] base;
    assign base = {rd_idx[p], {VBL{1'b0}}};
    always_comb begin
      rd_val[p] = mem[base +: VBITS];
      if (vw_acc && vw_idx == rd_idx[p]) rd_val[p] = vw_data;
      if (sw_acc && sw_reg == rd_idx[p]) rd_val[p][{sw_lane, 3'b000} +: 8] = sw_data;
    end
  end
  assign ra_data = rd_val[0];
  assign rb_data = rd_val[1];

  // String byte read with the same write-through
  logic [AW-1:0]  sr_base;
  logic [IW-1:0]  sr_reg;
  logic [LBW-1:0] sr_lane;
  assign sr_base = {sr_addr, 3'b000};
  assign sr_reg  = sr_addr[BW-1 -: IW];
  assign sr_lane = sr_addr[LBW-1:0];

  always_comb begin
    sr_data = mem[sr_base +: 8];
    if (vw_acc && vw_idx == sr_reg) sr_data = vw_data[{sr_lane, 3'b000} +: 8];
    if (sw_acc && sw_addr == sr_addr) sr_data = sw_data;
  end

  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(vw_acc || sw_acc)); // R8

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (busy && vw_valid) |-> wr_refused); // R8
endmodule

// File: tb/sim_vrb_bank.sv
module sim_vrb_bank;
  localparam int PER = 10;

  logic         clk = 1'b0;
  logic         rst, tr_start, busy, wr_refused;
  logic         vw_valid, vw_ready, sw_valid, sw_ready;
  logic [3:0]   vw_idx, ra_idx, rb_idx;
  logic [255:0] vw_data, ra_data, rb_data;
  logic [1:0]   sw_str, sr_str;
  logic [6:0]   sw_byte, sr_byte;
  logic [7:0]   sw_data, sr_data;

  always #(PER / 2) clk = ~clk;

  vrb_bank u0 (.*);

  int total = 0, failed = 0;
  bit done = 1'b0;
  logic [4095:0] model, expv;

  // kind(1) reg(4) byteaddr(9) byteval(8) word(64)
  localparam logic [85:0] TBL [8] = '{
    {1'b0, 4'd0,  9'd0,   8'h00, 64'h0123456789ABCDEF},
    {1'b0, 4'd15, 9'd0,   8'h00, 64'hFFFFFFFFFFFFFFFF},
    {1'b1, 4'd0,  9'd0,   8'h5A, 64'h0},
    {1'b1, 4'd0,  9'd31,  8'hC3, 64'h0},
    {1'b1, 4'd0,  9'd160, 8'h77, 64'h0},
    {1'b1, 4'd0,  9'd511, 8'h81, 64'h0},
    {1'b0, 4'd7,  9'd0,   8'h00, 64'hA5A55A5A0F0FF0F0},
    {1'b1, 4'd0,  9'd233, 8'hEE, 64'h0}
  };

  function automatic logic [255:0] vec_of(input logic [63:0] w);
    return {w ^ 64'h3, w ^ 64'h2, w ^ 64'h1, w};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    tr_start = 0; vw_valid = 0; sw_valid = 0;
  endtask

  task automatic check_bank(input logic [4095:0] e, input string tag);
    for (int r = 0; r < 16; r++) begin
      ra_idx = 4'(r); #1;
      chk(ra_data === e[r*256 +: 256], tag, ra_data, e[r*256 +: 256]);
    end
  endtask

  task automatic vwrite(input int r, input logic [255:0] d);
    @(negedge clk);
    vw_valid = 1; vw_idx = 4'(r); vw_data = d;
    @(negedge clk);
    vw_valid = 0;
    model[r*256 +: 256] = d;
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end

  initial begin
    idle();
    vw_idx = 0; vw_data = 0; sw_str = 0; sw_byte = 0; sw_data = 0;
    ra_idx = 0; rb_idx = 0; sr_str = 0; sr_byte = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model = '0;

    // R9: reset state
    #1;
    chk(busy === 1'b0, "R9 busy after reset", 256'(busy), 0);
    check_bank(model, "R9 bank cleared");

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      logic [85:0] t;
      int rg, ba;
      t = TBL[i];
      @(negedge clk);
      if (t[85] == 1'b0) begin
        rg = int'(t[84:81]);
        vw_valid = 1; vw_idx = t[84:81]; vw_data = vec_of(t[63:0]);
        ra_idx = t[84:81]; #1;
        chk(ra_data === vw_data, "R2 vector bypass", ra_data, vw_data);
        model[rg*256 +: 256] = vec_of(t[63:0]);
      end else begin
        ba = int'(t[80:72]);
        rg = ba / 32;
        sw_valid = 1; {sw_str, sw_byte} = t[80:72]; sw_data = t[71:64];
        {sr_str, sr_byte} = t[80:72]; #1;
        chk(sr_data === t[71:64], "R2 string bypass", 256'(sr_data), 256'(t[71:64]));
        model[ba*8 +: 8] = t[71:64];
      end
      @(negedge clk);
      idle();
      rb_idx = 4'(rg); #1;
      chk(rb_data === model[rg*256 +: 256], "R1 R4 readback", rb_data, model[rg*256 +: 256]);
      if (t[85]) begin
        {sr_str, sr_byte} = t[80:72]; #1;
        chk(sr_data === model[int'(t[80:72])*8 +: 8], "R3 byte map",
            256'(sr_data), 256'(model[int'(t[80:72])*8 +: 8]));
      end
    end
    check_bank(model, "R4 only addressed bytes changed");

    // R3: explicit mapping, string 2 byte 70 -> reg 10 bits [6*8 +: 8]
    vwrite(10, {32{8'h00}} | (256'hD4 << 48));
    sr_str = 2; sr_byte = 70; #1;
    chk(sr_data === 8'hD4, "R3 string 2 byte 70", 256'(sr_data), 256'hD4);

    // R5: both ports valid, vector wins
    @(negedge clk);
    vw_valid = 1; vw_idx = 4'd3; vw_data = {8{32'hCAFEF00D}};
    sw_valid = 1; sw_str = 2; sw_byte = 0; sw_data = 8'h99;
    #1;
    chk(sw_ready === 1'b0, "R5 string ready low", 256'(sw_ready), 0);
    @(negedge clk);
    idle();
    model[3*256 +: 256] = {8{32'hCAFEF00D}};
    check_bank(model, "R5 string write not applied");

    // Fill for transpose
    for (int r = 0; r < 16; r++) begin
      logic [255:0] d;
      for (int q = 0; q < 4; q++) d[q*64 +: 64] = 64'h9E3779B97F4A7C15 * 64'(4*r + q + 1);
      vwrite(r, d);
    end
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) expv[r*64 + c] = model[c*64 + r];

    // R6 R7 R8 R10: transpose run
    begin
      int cnt;
      @(negedge clk);
      tr_start = 1; vw_valid = 1; vw_idx = 0; vw_data = '1; #1;
      chk(vw_ready === 1'b0, "R8 ready low in command cycle", 256'(vw_ready), 0);
      @(negedge clk);
      idle();
      cnt = 0;
      while (busy === 1'b1 && cnt < 200) begin
        if (cnt == 5) begin
          vw_valid = 1; vw_idx = 2; vw_data = '1; sw_valid = 1; sw_str = 1; sw_byte = 3; sw_data = 8'hFF;
          #1;
          chk(wr_refused === 1'b1, "R8 refused flag", 256'(wr_refused), 1);
          chk(vw_ready === 1'b0 && sw_ready === 1'b0, "R8 readies low", 256'({vw_ready, sw_ready}), 0);
        end
        if (cnt == 6) begin idle(); tr_start = 1; end
        if (cnt == 7) idle();
        cnt++;
        @(negedge clk);
      end
      idle();
      chk(cnt == 64, "R6 busy length (R10 restart ignored)", 256'(cnt), 64);
      check_bank(expv, "R7 transposed bank");
    end

    // R7: second transpose returns the original
    @(negedge clk); tr_start = 1;
    @(negedge clk); idle();
    repeat (64) @(negedge clk);
    #1;
    chk(busy === 1'b0, "R6 second run done", 256'(busy), 0);
    check_bank(model, "R7 double transpose restores");

    // R9: reset mid-transpose
    @(negedge clk); tr_start = 1;
    @(negedge clk); idle();
    repeat (10) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0; #1;
    chk(busy === 1'b0, "R9 reset ends transpose", 256'(busy), 0);
    check_bank('0, "R9 reset clears mid-run");
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0, "R9 stays idle", 256'(busy), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule